// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block keeps the pending-request vector of one interrupt controller. Every request line can be set to edge-sensitive or level-sensitive through a trigger-mode register. Raw request inputs pass through a two-stage synchronizer. The block keeps the previous sampled level of each line so that it can detect rising edges. Priority resolution, masking and the processor interface sit in other blocks. Those blocks read the pending vector and return an acknowledge strobe with the index of the line that was serviced.

An edge-sensitive line latches a request when its sampled level goes from low to high, and the request stays pending until that line is acknowledged. A level-sensitive line's request bit follows the sampled level and does not react to an acknowledge. Each instance has a writable-bit mask as a parameter, and trigger-mode bits outside this mask always read as zero, which means edge-sensitive. An initialization pulse clears the pending vector and the stored previous levels.

Top module: `irq_req_latch`

## Requirements
- R1: For a line whose trigger-mode bit is 1 (level), `req_vec` follows `req_in`. A change on `req_in` shows on `req_vec` at the third rising clock edge after it, because of two synchronizer stages and one register.
- R2: For a line whose trigger-mode bit is 0 (edge), a synchronized high sample while the stored previous level is low sets the request bit.
- R3: For an edge line, a low input clears only the stored previous level. A request that is already set stays set.
- R4: The stored previous level is updated from every sample in both modes. A line that was high while it was level-sensitive and is then switched to edge mode does not latch a new request after it is acknowledged.
- R5: When `ack_valid` is high, the request bit of line `ack_line` is cleared if that line is edge-sensitive. An acknowledge to a level line has no effect.
- R6: If an acknowledge and a fresh rising edge reach the same edge line in the same cycle, the request stays set.
- R7: A trigger-mode write stores `trig_wr_data & WR_MASK`, and `trig_rd_data` returns the stored value. Lines outside the mask stay edge-sensitive.
- R8: An `init_clr` pulse clears the request vector and the stored previous levels in the next cycle. An edge line whose input is still high therefore latches again one cycle later.
- R9: After reset, `req_vec` and `trig_rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_clr | input | 1 | Initialization pulse that clears requests and previous levels |
| req_in | input | LINES | Raw asynchronous request lines |
| trig_wr_en | input | 1 | Trigger-mode register write strobe |
| trig_wr_data | input | LINES | Trigger-mode write data (1 = level) |
| trig_rd_data | output | LINES | Trigger-mode register readback |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | IW | Index of the acknowledged line |
| req_vec | output | LINES | Pending request vector |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge as a newly detected rising edge on the same line. The bench raises the input exactly two cycles before it drives the acknowledge, which lines the acknowledge up with the edge leaving the synchronizer. A second hard case is the history of the previous level across a trigger-mode change. The bench holds a line high while it is level-sensitive, switches it to edge mode and acknowledges it, then checks that it stays clear.

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] WR_MASK = LINES'(8'hF8),
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_clr,
  input  logic [LINES-1:0] req_in,
  input  logic             trig_wr_en,
  input  logic [LINES-1:0] trig_wr_data,
  output logic [LINES-1:0] trig_rd_data,
  input  logic             ack_valid,
  input  logic [IW-1:0]    ack_line,
  output logic [LINES-1:0] req_vec
);

  logic [LINES-1:0] sync1, samp, prev, trig, req, ack_hit, rise, req_nxt;

  assign ack_hit = ack_valid ? (LINES'(1) << ack_line) : '0;
  assign rise    = samp & ~prev;
  assign req_nxt = (trig & samp) | (~trig & ((req & ~ack_hit) | rise));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      samp  <= '0;
      prev  <= '0;
      trig  <= '0;
      req   <= '0;
    end else begin
      sync1 <= req_in;
      samp  <= sync1;
      if (trig_wr_en) trig <= trig_wr_data & WR_MASK;
      if (init_clr) begin
        req  <= '0;
        prev <= '0;
      end else begin
        req  <= req_nxt;
        prev <= samp;
      end
    end
  end

  assign req_vec      = req;
  assign trig_rd_data = trig;

  // R1: level lines mirror the previous sample
  p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_clr |=> ((req & $past(trig)) == ($past(samp) & $past(trig))));

  // R2: rising sample on an edge line is latched
  p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_clr |=> (($past(rise & ~trig) & ~req) == '0));

  // R3: edge request held without acknowledge
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_clr |=> (($past(req & ~trig & ~ack_hit) & ~req) == '0));

  // R4: previous level tracks every sample
  p_prev_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !init_clr |=> (prev == $past(samp)));

  // R5: acknowledged edge line without fresh rise is cleared
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !init_clr |=> (($past(ack_hit & ~trig & ~rise) & req) == '0));

  // R7: stored mode never holds fixed-edge bits
  p_trig_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_en |=> (trig_rd_data == ($past(trig_wr_data) & WR_MASK)));

  // R8: initialization clears state
  p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (req == '0 && prev == '0));

endmodule

// File: tb/irq_req_latch_tb_top.sv
`timescale 1ns/1ps
module irq_req_latch_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_clr = 1'b0;
  logic [7:0] req_in = '0;
  logic       trig_wr_en = 1'b0;
  logic [7:0] trig_wr_data = '0;
  logic [7:0] trig_rd_data;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_line = '0;
  logic [7:0] req_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_req_latch #(.LINES(8), .WR_MASK(8'hF8)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .req_in(req_in),
    .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
    .trig_rd_data(trig_rd_data), .ack_valid(ack_valid),
    .ack_line(ack_line), .req_vec(req_vec)
  );

  // {req_in, ack_valid, ack_line, expected req_vec}, trigger mode 0xF0
  localparam logic [19:0] VEC [0:7] = '{
    20'h00000, // R1 idle
    20'hFF0FF, // R1 R2 all high
    20'h0000F, // R1 R3 levels drop, edges held
    20'h0090D, // R5 ack edge line 1
    20'h30C3D, // R5 ack level line 4 ignored
    20'h0580C, // R5 ack edge line 0
    20'h00B04, // R5 ack edge line 3
    20'h0BA0B  // R2 R5 new edges, ack line 2
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] in, input logic av, input logic [2:0] ln);
    @(negedge clk);
    req_in = in;
    repeat (3) @(negedge clk);
    if (av) begin
      ack_valid = 1'b1;
      ack_line  = ln;
      @(negedge clk);
      ack_valid = 1'b0;
    end
  endtask

  task automatic wr_trig(input logic [7:0] d);
    @(negedge clk);
    trig_wr_en   = 1'b1;
    trig_wr_data = d;
    @(negedge clk);
    trig_wr_en   = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset req", req_vec, 8'h00);
    check("R9 reset trig", trig_rd_data, 8'h00);
    rst_n = 1'b1;

    wr_trig(8'hF0);
    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][19:12], VEC[i][11], VEC[i][10:8]);
      check($sformatf("R1/R2/R3/R5 vector %0d", i), req_vec, VEC[i][7:0]);
    end

    wr_trig(8'hFF);
    check("R7 masked readback", trig_rd_data, 8'hF8);
    apply(8'h00, 1'b0, 3'd0);
    check("R7 fixed edge line 0 held", {7'b0, req_vec[0]}, 8'h01);

    wr_trig(8'h10);
    apply(8'h10, 1'b0, 3'd0);
    check("R4 level line 4 high", {7'b0, req_vec[4]}, 8'h01);
    wr_trig(8'h00);
    apply(8'h10, 1'b1, 3'd4);
    check("R4 ack after mode switch", {7'b0, req_vec[4]}, 8'h00);
    repeat (3) @(negedge clk);
    check("R4 no false edge", {7'b0, req_vec[4]}, 8'h00);

    apply(8'h14, 1'b0, 3'd0);
    apply(8'h10, 1'b0, 3'd0);
    @(negedge clk);
    req_in = 8'h14;
    repeat (2) @(negedge clk);
    ack_valid = 1'b1;
    ack_line  = 3'd2;
    @(negedge clk);
    ack_valid = 1'b0;
    check("R6 ack with fresh rise", {7'b0, req_vec[2]}, 8'h01);
    apply(8'h14, 1'b1, 3'd2);
    check("R5 plain ack clears", {7'b0, req_vec[2]}, 8'h00);

    @(negedge clk);
    init_clr = 1'b1;
    @(negedge clk);
    init_clr = 1'b0;
    check("R8 init clears", req_vec, 8'h00);
    @(negedge clk);
    check("R8 relatch after init", req_vec, 8'h14);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule